// File: doc/BRIEF.md
# Dual-Channel DAC Command Decoder

This block is the digital front end of a two-channel 10-bit converter. A host writes one 16-bit command per chip-select window over a serial link made of a clock, a data line and an active-low select. The block holds each channel in two stages. A staging register takes new data. A live register drives the converter. A separate power state decides whether the analog outputs are driven or left floating.

The top four bits of each frame are a command code. The code decides which staging registers take the 10-bit payload, whether both live registers copy their staging registers, and whether the part wakes or sleeps. The serial pins are brought into the system clock domain through two-stage synchronizers. A frame takes effect a few system clocks after the select line returns high, and only when exactly sixteen data bits were clocked in.

Top module: `dac_cmd_decoder`

## Requirements
- R1: After reset both live codes read 0, both staging registers hold 0, and out_en is 1 (awake).
- R2: Bits are taken on rising sclk while cs_n is low, most significant bit first. Frame bit 15..12 is the command code and bit 11..2 is the 10-bit payload. Bits 1..0 are ignored.
- R3: A frame executes on the rising edge of cs_n only if exactly 16 bits were clocked in. A frame with fewer or more bits changes no register and not the power state.
- R4: Code 0000 and the unassigned codes 0011, 0100, 0101, 0110, 0111, 1011 and 1100 change nothing.
- R5: Code 0001 writes the payload to staging A. Code 0010 writes it to staging B. Neither changes a live register or the power state.
- R6: Code 1000 copies both staging registers to the live registers and wakes the part.
- R7: Code 1001 writes the payload to staging A. It then loads live A from the new value and live B from the existing staging B, and wakes the part.
- R8: Code 1010 writes the payload to staging B. It then loads live A from the existing staging A and live B from the new value, and wakes the part.
- R9: Code 1101 wakes the part and leaves all four registers unchanged.
- R10: Code 1110 sets out_en to 0 and leaves all four registers unchanged. The live codes keep their values on dac_a and dac_b.
- R11: Code 1111 writes the payload to both staging registers and both live registers, and wakes the part.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial bit clock from the host |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial command data |
| dac_a | output | DATA_W | Live code of channel A |
| dac_b | output | DATA_W | Live code of channel B |
| out_en | output | 1 | 1 when awake; 0 when the analog outputs float |

## Verification
The bench uses the default build: a 10-bit payload and two pad bits, so each frame is 16 bits. At this size all sixteen command codes can be swept. Each code runs from both an asleep and an awake start and with four payload and pad patterns. After each command a copy-both command brings the staging registers out to the ports. This makes load-only effects and no-op effects visible. Frames of 15 and 17 bits carrying the most invasive code check that miscounted frames are thrown away.

// File: rtl/dac_cmd_decoder.sv
module dac_cmd_decoder #(
  parameter int DATA_W = 10,
  parameter int PAD_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic [DATA_W-1:0] dac_a,
  output logic [DATA_W-1:0] dac_b,
  output logic              out_en
);
  localparam int CODE_W  = 4;
  localparam int HDR_W   = CODE_W + DATA_W;
  localparam int FRAME_W = HDR_W + PAD_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  localparam logic [CODE_W-1:0] OP_LD_A   = 4'b0001;
  localparam logic [CODE_W-1:0] OP_LD_B   = 4'b0010;
  localparam logic [CODE_W-1:0] OP_UPD    = 4'b1000;
  localparam logic [CODE_W-1:0] OP_UPD_A  = 4'b1001;
  localparam logic [CODE_W-1:0] OP_UPD_B  = 4'b1010;
  localparam logic [CODE_W-1:0] OP_WAKE   = 4'b1101;
  localparam logic [CODE_W-1:0] OP_SLEEP  = 4'b1110;
  localparam logic [CODE_W-1:0] OP_BOTH   = 4'b1111;

  logic [2:0]        sclk_s, cs_s;
  logic [1:0]        mosi_s;
  logic [HDR_W-1:0]  hdr;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] in_a, in_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      cs_s   <= {cs_s[1:0], cs_n};
      mosi_s <= {mosi_s[0], mosi};
    end

  wire sclk_rise = sclk_s[1] & ~sclk_s[2];
  wire cs_rise   = cs_s[1] & ~cs_s[2];
  wire selected  = ~cs_s[1];
  wire exec      = cs_rise && (cnt == CNT_W'(FRAME_W));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hdr <= '0;
      cnt <= '0;
    end else if (!selected) begin
      cnt <= '0;
    end else if (sclk_rise) begin
      if (cnt < CNT_W'(HDR_W)) hdr <= {hdr[HDR_W-2:0], mosi_s[1]};
      if (cnt <= CNT_W'(FRAME_W)) cnt <= cnt + 1'b1;
    end

  wire [CODE_W-1:0] code = hdr[HDR_W-1 -: CODE_W];
  wire [DATA_W-1:0] data = hdr[DATA_W-1:0];

  wire ld_a  = (code == OP_LD_A) || (code == OP_UPD_A) || (code == OP_BOTH);
  wire ld_b  = (code == OP_LD_B) || (code == OP_UPD_B) || (code == OP_BOTH);
  wire upd   = (code == OP_UPD) || (code == OP_UPD_A) || (code == OP_UPD_B) || (code == OP_BOTH);
  wire wake  = upd || (code == OP_WAKE);
  wire sleep = (code == OP_SLEEP);

  wire [DATA_W-1:0] in_a_nxt = ld_a ? data : in_a;
  wire [DATA_W-1:0] in_b_nxt = ld_b ? data : in_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_a   <= '0;
      in_b   <= '0;
      dac_a  <= '0;
      dac_b  <= '0;
      out_en <= 1'b1;
    end else if (exec) begin
      in_a <= in_a_nxt;
      in_b <= in_b_nxt;
      if (upd) begin
        dac_a <= in_a_nxt;
        dac_b <= in_b_nxt;
      end
      if (wake)       out_en <= 1'b1;
      else if (sleep) out_en <= 1'b0;
    end

  assert_bad_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cnt != CNT_W'(FRAME_W)) |=>
      ($stable(dac_a) && $stable(dac_b) && $stable(in_a) && $stable(in_b) && $stable(out_en)));

  assert_reserved_nop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (code inside {4'b0000, 4'b0011, 4'b0100, 4'b0101, 4'b0110, 4'b0111, 4'b1011, 4'b1100})) |=>
      ($stable(dac_a) && $stable(dac_b) && $stable(in_a) && $stable(in_b) && $stable(out_en)));

  assert_load_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (code == OP_LD_A || code == OP_LD_B)) |=>
      ($stable(dac_a) && $stable(dac_b) && $stable(out_en)));

  assert_sleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && code == OP_SLEEP) |=> (!out_en && $stable(dac_a) && $stable(dac_b)));

  assert_same_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && code == OP_BOTH) |=> (dac_a == dac_b && out_en));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> ($stable(dac_a) && $stable(dac_b) && $stable(out_en)));
endmodule

// File: tb/dac_cmd_decoder_test.sv
module dac_cmd_decoder_test;
  localparam int DW = 10;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [DW-1:0] dac_a, dac_b;
  logic out_en;
  int tests = 0, fails = 0;

  logic [DW-1:0] m_in_a, m_in_b, m_dac_a, m_dac_b;
  logic m_awake;

  always #10 clk = ~clk;

  dac_cmd_decoder #(.DATA_W(DW), .PAD_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .dac_a(dac_a), .dac_b(dac_b), .out_en(out_en)
  );

  function automatic string tag(input logic [3:0] c);
    case (c)
      4'b0001, 4'b0010: return "R5";
      4'b1000: return "R6";
      4'b1001: return "R7";
      4'b1010: return "R8";
      4'b1101: return "R9";
      4'b1110: return "R10";
      4'b1111: return "R11";
      default: return "R4";
    endcase
  endfunction

  task automatic model(input logic [3:0] c, input logic [DW-1:0] d);
    logic la, lb, up;
    la = (c == 4'b0001) || (c == 4'b1001) || (c == 4'b1111);
    lb = (c == 4'b0010) || (c == 4'b1010) || (c == 4'b1111);
    up = (c == 4'b1000) || (c == 4'b1001) || (c == 4'b1010) || (c == 4'b1111);
    if (la) m_in_a = d;
    if (lb) m_in_b = d;
    if (up) begin m_dac_a = m_in_a; m_dac_b = m_in_b; end
    if (up || c == 4'b1101) m_awake = 1'b1;
    else if (c == 4'b1110) m_awake = 1'b0;
  endtask

  task automatic send(input logic [3:0] c, input logic [DW-1:0] d,
                      input logic [1:0] pad, input int nbits);
    logic [16:0] w;
    w = {c, d, pad, 1'b0};
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = w[16 - i];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    if (nbits == 16) model(c, d);
  endtask

  task automatic check(input string req);
    tests++;
    if (dac_a !== m_dac_a || dac_b !== m_dac_b || out_en !== m_awake) begin
      fails++;
      $display("FAIL %s: got a=%0d b=%0d en=%0b, expected a=%0d b=%0d en=%0b",
               req, dac_a, dac_b, out_en, m_dac_a, m_dac_b, m_awake);
    end
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_in_a = '0; m_in_b = '0; m_dac_a = '0; m_dac_b = '0; m_awake = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1");
    send(4'b1000, 10'h3FF, 2'b11, 16);
    check("R1");

    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 4; k++) begin
        logic [DW-1:0] da, db, dt;
        da = DW'((c * 73 + k * 211 + 5) % 1024);
        db = DW'((c * 131 + k * 97 + 600) % 1024);
        dt = DW'((c * 389 + k * 517 + 1) % 1024);
        send(4'b0001, da, 2'(k), 16);
        send(4'b0010, db, 2'(3 - k), 16);
        send(k[0] ? 4'b1110 : 4'b1101, 10'h155, 2'b10, 16);
        check("R2");
        send(4'(c), dt, 2'(k), 16);
        check(tag(4'(c)));
        send(4'b1000, 10'h000, 2'b01, 16);
        check(tag(4'(c)));
      end
    end

    send(4'b0001, 10'h2A5, 2'b00, 16);
    send(4'b0010, 10'h15A, 2'b00, 16);
    send(4'b1110, 10'h000, 2'b00, 16);
    send(4'b1111, 10'h3C3, 2'b11, 15);
    check("R3");
    send(4'b1111, 10'h3C3, 2'b11, 17);
    check("R3");
    send(4'b1000, 10'h000, 2'b00, 16);
    check("R3");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule